// File: doc/BRIEF.md
# Clocked Serial Byte Receiver

The block receives 8-bit words over a two-wire synchronous link: a serial clock and a serial data line. Bits are sampled on the rising edge of the serial clock, least-significant bit first. After eight bits the word is copied to a host-readable buffer and `full_o` is raised. `full_o` serves as the buffer-full interrupt request. The host controls reception through a small strobe interface: an enable write, an abort strobe and a buffer read strobe. It monitors `busy_o` to learn when reception has ended.

There are two clock sources. With the internal source, the block drives `sclk_o` from a fixed divider of the system clock. The clock idles high and halts at a byte boundary while the previous word is still unread, so data is never lost. With the external source, `sclk_i` is brought into the system clock domain through a synchronizer and shifting follows its rising edges with no wait. A word left unread is then replaced by the next one.

Reception can end in two ways. Clearing the enable lets the current word finish before the block goes idle. An abort ends reception at once and discards the partial word.

Top module: `serial_rx_ctrl`

## Requirements
- R1: Each shift event samples the data line into the shift register. The first sampled bit becomes bit 0 of the word. On the eighth event the word is written to `data_o` and `full_o` rises in that same system cycle.
- R2: An enable write (`start_wr_i` high with `start_val_i`=1) starts reception only while `rx_mode_i`=1. While `rx_mode_i`=0 the write is ignored and `busy_o` stays 0.
- R3: With the internal source (`clk_src_i`=0), `sclk_o` is 1 whenever `busy_o` is 0. Each phase of `sclk_o` lasts HALF_CYC system cycles, and data is sampled as `sclk_o` rises.
- R4: With the internal source, if `full_o` is still 1 when a word boundary is reached, `sclk_o` stays high and `busy_o` stays 1 until the host reads the buffer. After the read the next word is received.
- R5: With the external source (`clk_src_i`=1), a rising edge of `sclk_i` causes a shift after a two-flop synchronizer. There is no wait: a second word overwrites an unread first word, and `full_o` stays 1.
- R6: An enable write with `start_val_i`=0 during a word lets that word complete into `data_o` with `full_o`. `busy_o` then drops to 0 and no further word is received.
- R7: An abort pulse clears `busy_o` on the next cycle and returns `sclk_o` high. It discards the partial word, and `full_o` does not rise for it.
- R8: A read strobe `rd_i` clears `full_o` on the next cycle and leaves `data_o` unchanged.
- R9: A change of `rx_mode_i` clears `data_o` to 0 and `full_o` to 0.
- R10: After reset, `busy_o`=0, `full_o`=0, `data_o`=0, `sclk_o`=1 and `enable_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_mode_i | input | 1 | Receive mode selected; a change clears the buffer |
| clk_src_i | input | 1 | 0 = internal serial clock, 1 = external |
| start_wr_i | input | 1 | Write strobe for the enable bit |
| start_val_i | input | 1 | Value written to the enable bit |
| abort_i | input | 1 | Immediate abort strobe |
| rd_i | input | 1 | Buffer read strobe |
| sclk_i | input | 1 | External serial clock |
| sdi_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Internally generated serial clock, idles high |
| data_o | output | 8 | Received word buffer |
| full_o | output | 1 | Buffer full / interrupt request |
| busy_o | output | 1 | Reception active |
| enable_o | output | 1 | Current enable bit |

## Verification
The bench targets the internal-clock stall with an unread word. A design that keeps clocking would lose the second word or move `sclk_o` while the host is behind. It stops reception partway through a word and checks that exactly that word arrives and `busy_o` then falls. A design that stops at once would leave the buffer empty. A design that keeps going would deliver another word. An abort partway through a word must leave `full_o` low and the clock idle high. A design that flushes the partial word would raise a spurious interrupt. In external mode a second unread word must overwrite the first, which catches a design that wrongly stalls. A mode toggle must empty the buffer, and a start with receive mode off must be ignored.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int unsigned WORD_W = 8;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} clk_src_e;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic halt_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] div_q;
  logic          sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (halt_i) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!sclk_q || run_i) begin
      // a low phase always finishes; a high phase only advances when allowed
      if (div_q == LAST) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end else begin
      div_q <= '0;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = !halt_i && !sclk_q && (div_q == LAST);
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic sdi_o
);
  logic [STAGES-1:0] ck_q, d_q;
  logic              ck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q      <= '1;
      d_q       <= '0;
      ck_prev_q <= 1'b1;
    end else begin
      ck_q      <= {ck_q[STAGES-2:0], sclk_i};
      d_q       <= {d_q[STAGES-2:0], sdi_i};
      ck_prev_q <= ck_q[STAGES-1];
    end
  end

  assign rise_o = ck_q[STAGES-1] & ~ck_prev_q;
  assign sdi_o  = d_q[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         cnt_zero_o,
  output logic         done_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {bit_i, sr_q[W-1:1]};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_zero_o = (cnt_q == '0);
  assign done_o     = shift_i && (cnt_q == LAST);
  assign word_o     = {bit_i, sr_q[W-1:1]};
endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_mode_i,
  input  logic              clk_src_i,
  input  logic              start_wr_i,
  input  logic              start_val_i,
  input  logic              abort_i,
  input  logic              rd_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic [WORD_W-1:0] data_o,
  output logic              full_o,
  output logic              busy_o,
  output logic              enable_o
);
  clk_src_e src;
  assign src = clk_src_e'(clk_src_i);

  logic en_q, busy_q, full_q, mode_q;
  logic [WORD_W-1:0] data_q;
  logic int_rise, ext_rise, ext_sdi, cnt_zero, done, shift, run, halt, clr;
  logic [WORD_W-1:0] word;

  // high phase may start a new bit only when the word boundary is not blocked
  assign run  = busy_q && (src == SRC_INT) && !(cnt_zero && (full_q || !en_q));
  assign halt = abort_i || !busy_q || (src == SRC_EXT);

  sclk_gen #(.HALF_CYC(HALF_CYC)) u_gen (
    .clk_i, .rst_ni, .run_i(run), .halt_i(halt), .sclk_o, .rise_o(int_rise)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .sdi_i, .rise_o(ext_rise), .sdi_o(ext_sdi)
  );

  assign shift = busy_q && !abort_i && ((src == SRC_EXT) ? ext_rise : int_rise);
  assign clr   = abort_i || (start_wr_i && start_val_i && rx_mode_i && !busy_q);

  rx_shifter #(.W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(clr), .shift_i(shift),
    .bit_i((src == SRC_EXT) ? ext_sdi : sdi_i),
    .cnt_zero_o(cnt_zero), .done_o(done), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (abort_i) begin
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (start_wr_i && rx_mode_i) begin
      en_q <= start_val_i;
      if (start_val_i) busy_q <= 1'b1;
    end else if (busy_q && !en_q && cnt_zero) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      mode_q <= rx_mode_i;
      if (mode_q != rx_mode_i) begin
        data_q <= '0;
        full_q <= 1'b0;
      end else if (done) begin
        data_q <= word;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign data_o   = data_q;
  assign full_o   = full_q;
  assign busy_o   = busy_q;
  assign enable_o = en_q;
endmodule

// File: rtl/serial_rx_ctrl_chk.sv
module serial_rx_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_mode_i,
  input logic       clk_src_i,
  input logic       start_wr_i,
  input logic       start_val_i,
  input logic       abort_i,
  input logic       rd_i,
  input logic       sclk_o,
  input logic [7:0] data_o,
  input logic       full_o,
  input logic       busy_o
);
  // R7
  abort_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o);

  // R3
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_src_i && $stable(clk_src_i) && full_o && sclk_o && !rd_i) |=> sclk_o);

  // R2
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_wr_i && start_val_i && rx_mode_i));

  // R1
  full_in_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> busy_o);

  // R8
  full_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> ($past(rd_i) || ($past(rx_mode_i) != $past(rx_mode_i, 2))));

  // R9
  data_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> (full_o || data_o == 8'h00));
endmodule

bind serial_rx_ctrl serial_rx_ctrl_chk u_chk (
  .clk_i, .rst_ni, .rx_mode_i, .clk_src_i, .start_wr_i, .start_val_i,
  .abort_i, .rd_i, .sclk_o, .data_o, .full_o, .busy_o
);

// File: tb/serial_rx_ctrl_test.sv
module serial_rx_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_mode = 1'b0, clk_src = 1'b0, start_wr = 1'b0, start_val = 1'b0;
  logic abort = 1'b0, rd = 1'b0, sclk_in = 1'b1, sdi = 1'b0;
  logic sclk_out, full, busy, enable;
  logic [7:0] data;

  int n_vec = 0, n_bad = 0;
  bit   bitq[$];
  logic [7:0] expq[$];
  logic full_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_ctrl #(.HALF_CYC(HALF)) uut (
    .clk_i(clk), .rst_ni, .rx_mode_i(rx_mode), .clk_src_i(clk_src),
    .start_wr_i(start_wr), .start_val_i(start_val), .abort_i(abort), .rd_i(rd),
    .sclk_i(sclk_in), .sdi_i(sdi), .sclk_o(sclk_out), .data_o(data),
    .full_o(full), .busy_o(busy), .enable_o(enable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: bits for the internal clock, expected word into the scoreboard
  task automatic push_bits(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bitq.push_back(b[i]);
  endtask
  task automatic push_word(input logic [7:0] b);
    push_bits(b);
    expq.push_back(b);
  endtask

  always @(negedge sclk_out) if (bitq.size() != 0) sdi = bitq.pop_front();

  // monitor: pop and compare on each new buffer-full
  always @(negedge clk) begin
    if (rst_ni && full && !full_prev) begin
      if (expq.size() == 0) check(1'b0, "R1 unexpected word", data, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(data == e, "R1 received word", data, e);
      end
    end
    full_prev = full;
  end

  task automatic pulse_start(input logic v);
    @(negedge clk); start_wr = 1'b1; start_val = v;
    @(negedge clk); start_wr = 1'b0;
  endtask
  task automatic pulse_rd;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask
  task automatic pulse_abort;
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask
  task automatic ext_word(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk_in = 1'b0; sdi = b[i];
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    realtime t0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !full && data == 0 && sclk_out && !enable, "R10 reset", {busy, full, sclk_out, enable}, 4'b0010);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 start ignored outside receive mode
    pulse_start(1'b1);
    repeat (3) @(negedge clk);
    check(!busy && !enable, "R2 start ignored", busy, 0);
    rx_mode = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R3 internal clock, single word, phase length
    push_word(8'hA5);
    pulse_start(1'b1);
    check(busy, "R2 start accepted", busy, 1);
    @(negedge sclk_out); t0 = $realtime;
    @(posedge sclk_out);
    check(($realtime - t0) == HALF * CLK_PERIOD, "R3 phase length", int'($realtime - t0), HALF * CLK_PERIOD);
    wait (full); @(negedge clk);

    // R4 stall while unread
    push_word(8'h3C);
    repeat (100) @(negedge clk);
    check(sclk_out == 1'b1, "R4 clock held high", sclk_out, 1);
    check(busy && data == 8'hA5, "R4 busy, buffer kept", data, 8'hA5);
    pulse_rd;
    // R8 read clears full, data kept
    check(!full && data == 8'hA5, "R8 read clears full", {full, data}, 9'h0A5);
    wait (full); @(negedge clk);
    check(bitq.size() == 0, "R4 resumed after read", bitq.size(), 0);

    // R6 graceful stop mid-word
    push_word(8'h96);
    push_bits(8'hFF);
    pulse_rd;
    repeat (3) @(posedge sclk_out);
    pulse_start(1'b0);
    check(busy, "R6 still busy after stop", busy, 1);
    wait (full);
    repeat (3) @(negedge clk);
    check(!busy, "R6 busy drops", busy, 0);
    repeat (80) @(negedge clk);
    check(full && data == 8'h96 && sclk_out, "R6 no further word", data, 8'h96);
    bitq.delete();

    // R9 mode change clears the buffer
    @(negedge clk); rx_mode = 1'b0;
    @(negedge clk);
    check(!full && data == 8'h00, "R9 mode change clears", {full, data}, 0);
    rx_mode = 1'b1;
    repeat (2) @(negedge clk);

    // R7 abort mid-word
    push_bits(8'h55);
    pulse_start(1'b1);
    repeat (4) @(posedge sclk_out);
    pulse_abort;
    check(!busy && sclk_out, "R7 abort idle", {busy, sclk_out}, 2'b01);
    repeat (80) @(negedge clk);
    check(!full && data == 8'h00, "R7 no word after abort", {full, data}, 0);
    bitq.delete();

    // R5 external clock, no wait, overwrite
    clk_src = 1'b1;
    repeat (2) @(negedge clk);
    pulse_start(1'b1);
    expq.push_back(8'h5A);
    ext_word(8'h5A);
    check(full && data == 8'h5A, "R5 external word", data, 8'h5A);
    ext_word(8'hE7);
    check(full && data == 8'hE7 && busy, "R5 overwrite without wait", data, 8'hE7);
    pulse_start(1'b0);
    repeat (2) @(negedge clk);
    check(!busy, "R6 external stop at boundary", busy, 0);

    check(expq.size() == 0, "R1 all words seen", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule